// File: doc/BRIEF.md
# Split High/Low-Time Clock Divider

This block divides a reference clock by an integer ratio and drives the result out as a clock. The ratio comes from a 15-bit control word. The word holds separate counts for the number of reference cycles the output stays high and the number it stays low. It also carries a half-cycle correction flag for odd ratios, a pass-through flag and a hold flag. The output period is the sum of the two counts. With the correction flag set, a falling-edge register moves the high-to-low transition half a reference cycle later, so an odd ratio gets an even duty cycle.

A new word is written with a one-cycle strobe into a staging register. The staged word is applied only at the end of a complete output period, so the output never shows a shortened pulse. If the hold flag is set in a written word, the word is staged but not armed, and it does not take effect. The next word written with the hold flag clear arms the staged value. After reset the divider is in pass-through.

Top module: `clk_div_hl`

## Requirements
- R1: Word fields: bits 5:0 are the low-time count, bits 11:6 the high-time count, bit 12 the half-cycle flag, bit 13 pass-through and bit 14 hold. When pass-through is off and the half-cycle flag is clear, the output period is high+low reference cycles, and the output is high for the first `high` of them.
- R2: With bit 13 set, `clk_o` follows `clk_i` and the period is one reference cycle, whatever the count fields hold.
- R3: With bit 12 set and pass-through off, the high phase lasts high+0.5 reference cycles and the low phase lasts low-0.5. The period is unchanged.
- R4: When pass-through is off, a high or low count of zero counts as 1.
- R5: A newly armed word takes effect only after the current output period has completed at the old ratio. The next period starts with its high phase.
- R6: A word written with bit 14 set does not take effect and clears any pending arm. A later write with bit 14 clear arms that new word, which is then adopted.
- R7: After reset the output follows `clk_i`, and it stays that way until a word is armed.
- R8: For every ratio N from 1 to 64 there is a standard encoding: low = ceil(N/2), high = floor(N/2), bit 12 = N mod 2, and bit 13 set only for N = 1. It gives a period of N reference cycles and a high time of N/2 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | One-cycle write strobe for `cfg_i` |
| cfg_i | input | 15 | Divider control word |
| clk_o | output | 1 | Divided clock |

## Verification
The hardest case to reach is a word that arrives partway through a long output period. The bench must show that the period already under way still completes at the old length. To do this it aligns to a rising edge of `clk_o` and writes a ratio-5 word one reference cycle into a ratio-8 period. It then measures the time to the next rising edge, which must still be eight cycles, and checks that the period after it is five. The hold flag is exercised in the same way: a held word is written, several periods of the old ratio are measured, and only then is an arming write issued.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  parameter int unsigned CNT_W = 6;
  localparam int unsigned WORD_W  = 2*CNT_W + 3;
  localparam int unsigned EDGE_B  = 2*CNT_W;
  localparam int unsigned BYP_B   = EDGE_B + 1;
  localparam int unsigned NOUPD_B = BYP_B + 1;

  typedef struct packed {
    logic             byp;
    logic             edge_en;
    logic [CNT_W-1:0] high;
    logic [CNT_W:0]   n;
  } div_cfg_t;

  // zero counts are promoted to 1
  function automatic div_cfg_t decode(input logic [NOUPD_B-1:0] w);
    div_cfg_t         d;
    logic [CNT_W-1:0] hi, lo;
    hi = w[2*CNT_W-1:CNT_W];
    lo = w[CNT_W-1:0];
    if (hi == '0) hi = CNT_W'(1);
    if (lo == '0) lo = CNT_W'(1);
    d.byp     = w[BYP_B];
    d.edge_en = w[EDGE_B];
    d.high    = hi;
    d.n       = {1'b0, hi} + {1'b0, lo};
    return d;
  endfunction
endpackage

// File: rtl/clkdiv_cfg_stage.sv
`timescale 1ns/1ps
module clkdiv_cfg_stage
  import clkdiv_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << BYP_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              boundary_i,
  output div_cfg_t          cur_o,
  output div_cfg_t          nxt_o,
  output logic              arm_o
);
  logic [NOUPD_B-1:0] stage_q;
  logic               arm_q;
  div_cfg_t           act_q;
  logic               load;

  assign load  = boundary_i & arm_q;
  assign nxt_o = load ? decode(stage_q) : act_q;
  assign cur_o = act_q;
  assign arm_o = arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= RESET_WORD[NOUPD_B-1:0];
      arm_q   <= 1'b0;
      act_q   <= decode(RESET_WORD[NOUPD_B-1:0]);
    end else begin
      act_q <= nxt_o;
      if (wr_i) begin
        stage_q <= word_i[NOUPD_B-1:0];
        arm_q   <= ~word_i[NOUPD_B];
      end else if (load) begin
        arm_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_phase_cnt.sv
`timescale 1ns/1ps
module clkdiv_phase_cnt
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cur_byp_i,
  input  logic [CNT_W:0]   cur_n_i,
  input  logic [CNT_W-1:0] nxt_high_i,
  output logic [CNT_W:0]   cnt_o,
  output logic             div_o,
  output logic             boundary_o
);
  logic [CNT_W:0] cnt_q, cnt_nxt;
  logic           div_q;

  assign boundary_o = cur_byp_i | (cnt_q == cur_n_i - 1'b1);
  assign cnt_nxt    = boundary_o ? '0 : cnt_q + 1'b1;
  assign cnt_o      = cnt_q;
  assign div_o      = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt < {1'b0, nxt_high_i});
    end
  end
endmodule

// File: rtl/clkdiv_edge_out.sv
`timescale 1ns/1ps
module clkdiv_edge_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic edge_en_i,
  input  logic byp_i,
  output logic clk_o
);
  logic div_n_q;

  // half-cycle retimed copy stretches the high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_n_q <= 1'b0;
    else         div_n_q <= div_i;
  end

  assign clk_o = byp_i ? clk_i : (div_i | (edge_en_i & div_n_q));
endmodule

// File: rtl/clk_div_hl.sv
`timescale 1ns/1ps
module clk_div_hl
  import clkdiv_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << BYP_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic              clk_o
);
  div_cfg_t       cur, nxt;
  logic           arm;
  logic           boundary;
  logic [CNT_W:0] cnt;
  logic           div;

  clkdiv_cfg_stage #(.RESET_WORD(RESET_WORD)) u_stage (
    .clk_i, .rst_ni,
    .wr_i(cfg_valid_i), .word_i(cfg_i), .boundary_i(boundary),
    .cur_o(cur), .nxt_o(nxt), .arm_o(arm)
  );

  clkdiv_phase_cnt u_cnt (
    .clk_i, .rst_ni,
    .cur_byp_i(cur.byp), .cur_n_i(cur.n), .nxt_high_i(nxt.high),
    .cnt_o(cnt), .div_o(div), .boundary_o(boundary)
  );

  clkdiv_edge_out u_out (
    .clk_i, .rst_ni,
    .div_i(div), .edge_en_i(cur.edge_en), .byp_i(cur.byp), .clk_o
  );
endmodule

// File: rtl/clk_div_hl_chk.sv
`timescale 1ns/1ps
module clk_div_hl_chk
  import clkdiv_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_valid_i,
  input logic           noupd_i,
  input logic           arm_i,
  input logic           boundary_i,
  input div_cfg_t       cur_i,
  input logic [CNT_W:0] cnt_i,
  input logic           div_i
);
  // R1: count stays inside the active period
  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_i.byp |-> (cnt_i < cur_i.n));

  // R1: the final cycle of a period is low
  p_last_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !cur_i.byp) |-> !div_i);

  // R5: configuration changes only at a period end
  p_cur_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(cur_i));

  // R5: a new period starts high
  p_restart_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> (cur_i.byp || div_i));

  // R6: a held write leaves nothing armed
  p_noupd_disarm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && noupd_i) |=> !arm_i);

  // R6: an armed word is consumed at the boundary
  p_arm_consumed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && arm_i && !cfg_valid_i) |=> !arm_i);
endmodule

bind clk_div_hl clk_div_hl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_valid_i(cfg_valid_i),
  .noupd_i(cfg_i[clkdiv_pkg::NOUPD_B]), .arm_i(arm), .boundary_i(boundary),
  .cur_i(cur), .cnt_i(cnt), .div_i(div)
);

// File: tb/sim_clk_div_hl.sv
`timescale 1ns/1ps
module sim_clk_div_hl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_valid_i = 1'b0;
  logic [14:0] cfg_i = '0;
  logic        clk_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  clk_div_hl u0 (.clk_i, .rst_ni, .cfg_valid_i, .cfg_i, .clk_o);

  // {word, period in half-cycles, high in half-cycles}
  localparam int NV = 8;
  localparam logic [46:0] VEC [NV] = '{
    {15'h0000 | (15'd3 << 6) | 15'd5, 16'd16, 16'd6},    // R1 high3 low5
    {15'h0000 | (15'd5 << 6) | 15'd2, 16'd14, 16'd10},   // R1 high5 low2
    {15'h1000 | (15'd2 << 6) | 15'd3, 16'd10, 16'd5},    // R3 edge
    {15'h1000 | (15'd4 << 6) | 15'd4, 16'd16, 16'd9},    // R3 edge even
    {15'h2000 | (15'd9 << 6) | 15'd9, 16'd2,  16'd1},    // R2 bypass
    {15'h0000,                        16'd4,  16'd2},    // R4 both zero
    {15'h0000 | 15'd3,                16'd8,  16'd2},    // R4 high zero
    {15'h0000 | (15'd63 << 6) | 15'd63, 16'd252, 16'd126} // R1 max counts
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [14:0] w);
    @(negedge clk_i);
    cfg_i = w;
    cfg_valid_i = 1'b1;
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic measure(output int per_h, output int hi_h);
    realtime t0, t1, t2;
    @(posedge clk_o);
    t0 = $realtime;
    @(negedge clk_o);
    t1 = $realtime;
    @(posedge clk_o);
    t2 = $realtime;
    per_h = int'((t2 - t0) / 2.5);
    hi_h  = int'((t1 - t0) / 2.5);
  endtask

  task automatic apply_and_measure(input logic [14:0] w, output int per_h, output int hi_h);
    write_word(w);
    wait_cyc(140);
    @(posedge clk_o);
    measure(per_h, hi_h);
  endtask

  function automatic logic [14:0] enc(input int n);
    logic [14:0] w;
    w = '0;
    w[5:0]  = 6'((n + 1) / 2);
    w[11:6] = 6'(n / 2);
    w[12]   = 1'(n % 2);
    w[13]   = (n == 1);
    return w;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p, h;
    realtime t0, t2;
    // R7: output follows clk_i during and after reset
    @(posedge clk_i); #1;
    check("R7 reset high", int'(clk_o), 1);
    @(negedge clk_i); #1;
    check("R7 reset low", int'(clk_o), 0);
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(200);
    measure(p, h);
    check("R7 period", p, 2);
    check("R7 high", h, 1);

    for (int i = 0; i < NV; i++) begin
      apply_and_measure(VEC[i][46:32], p, h);
      check($sformatf("R1/R2/R3/R4 vec%0d period", i), p, int'(VEC[i][31:16]));
      check($sformatf("R1/R2/R3/R4 vec%0d high", i), h, int'(VEC[i][15:0]));
    end

    // R8: sweep of the standard encoding
    for (int n = 1; n <= 64; n++) begin
      apply_and_measure(enc(n), p, h);
      check($sformatf("R8 N=%0d period", n), p, 2 * n);
      check($sformatf("R8 N=%0d high", n), h, n);
    end

    // R5: write lands one cycle into a ratio-8 period
    apply_and_measure(enc(8), p, h);
    check("R5 setup", p, 16);
    @(posedge clk_o);
    t0 = $realtime;
    write_word(enc(5));
    @(posedge clk_o);
    t2 = $realtime;
    check("R5 old period completes", int'((t2 - t0) / 2.5), 16);
    @(negedge clk_o);
    @(posedge clk_o);
    check("R5 new period", int'(($realtime - t2) / 2.5), 10);

    // R6: held word is ignored, arming write is adopted
    apply_and_measure(enc(4), p, h);
    check("R6 setup", p, 8);
    write_word(enc(7) | 15'h4000);
    wait_cyc(60);
    measure(p, h);
    check("R6 held ignored period", p, 8);
    check("R6 held ignored high", h, 4);
    write_word(enc(9) | 15'h4000);
    write_word(enc(9));
    wait_cyc(140);
    measure(p, h);
    check("R6 armed period", p, 18);
    // R6: held write cancels a pending arm
    write_word(enc(20));
    write_word(enc(6) | 15'h4000);
    wait_cyc(140);
    measure(p, h);
    check("R6 arm cancelled", p, 18);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule